// File: doc/BRIEF.md
# Daisy-Chain Readback Collector with Threshold Alerts

This block sits behind the serial receiver of a battery-monitor controller. The monitor devices are chained in series. After a broadcast conversion, the chain returns a burst of 32-bit response words: twelve per device, six cell-voltage channels followed by six auxiliary channels. The collector takes this burst one word at a time. It verifies each word's 8-bit CRC and pulls out the 4-bit channel index and the 12-bit result. It keeps a running total of the cell-voltage results only. Every result is also compared against one of two programmable threshold pairs, chosen by channel class. A crossing is reported as a one-cycle event that carries the channel, the device position and a direction bit.

A second mode sizes the chain at start-up. Each response word must carry a 5-bit device address. Read bit-reversed, that address must equal the running device index. An all-zero word ends the walk and yields the index of the last device. A chain that keeps answering past its maximum length is treated as a fault, as is a word with a bad CRC or a wrong address.

Top module: `cm_chain_readback`

## Requirements
- R1: A word is accepted only if bits 9:2 equal the remainder of bits 31:10 (a 22-bit message, MSB first) divided by x^8+x^5+x^3+x^2+x+1. In either mode, a rejected word ends the operation. The cycle after it, res_done and res_err are both high, busy is low, and no event is emitted for that word.
- R2: start_scan with dev_count N, 1 <= N <= MAX_DEV, makes the block collect exactly N*12 words. The cycle after the last word, res_done is high, res_err is low, and busy is low.
- R3: The channel index is bits 26:23 and the result is bits 22:11. res_sum is cleared at a scan start and adds the result only when the index is 5 or less. It holds its value while idle.
- R4: For an accepted word whose index is 5 or less, a result >= the cell high threshold gives an event with ev_rise=1. Otherwise, a result <= the cell low threshold gives ev_rise=0. The event comes one cycle after the word, with ev_chan equal to the index and ev_dev equal to the word's position divided by 12.
- R5: For an index of 6 or more, the auxiliary high/low pair is used under the same rule.
- R6: thr_we writes thr_wdata, read as two's complement and clamped to 0..255, into the threshold selected by thr_sel (0 cell high, 1 cell low, 2 aux high, 3 aux low). After reset, both high thresholds are 0xFF and both low thresholds are 0.
- R7: start_disc begins discovery. An all-zero word ends it without error and sets res_last to (accepted words - 1). An all-zero first word is an error.
- R8: In discovery, a nonzero word whose bits 31:27, read in reverse bit order, differ from the running index ends the walk with an error.
- R9: In discovery, the (MAX_DEV+1)-th consecutive valid nonzero word ends the walk with an error.
- R10: word_valid is ignored while idle. Starts are ignored while busy. If both starts arrive together, the scan wins.
- R11: start_scan with dev_count of 0 or above MAX_DEV completes at once as an error, with res_done and res_err high in the next cycle.
- R12: After reset, busy, res_done, res_err, ev_valid, res_sum and res_last are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_scan | input | 1 | Begin collecting a conversion burst |
| start_disc | input | 1 | Begin chain discovery |
| dev_count | input | 4 | Number of chained devices for a scan |
| word_valid | input | 1 | word_data holds a response word |
| word_data | input | 32 | Response word |
| thr_we | input | 1 | Threshold write strobe |
| thr_sel | input | 2 | Threshold select |
| thr_wdata | input | 16 | Signed threshold value before clamping |
| busy | output | 1 | Scan or discovery in progress |
| res_done | output | 1 | One-cycle completion strobe |
| res_err | output | 1 | Completion was a fault |
| res_sum | output | 18 | Sum of cell-voltage results |
| res_last | output | 3 | Index of last device found |
| ev_valid | output | 1 | Threshold event strobe |
| ev_chan | output | 4 | Channel index of the event |
| ev_dev | output | 3 | Device position of the event |
| ev_rise | output | 1 | 1 rising, 0 falling |

## Verification
The bench targets the device and class boundaries. An index of 5 against 6 decides both summing and the choice of threshold pair, so a design off by one there would fold auxiliary readings into the total or alert against the wrong pair. A result exactly equal to a threshold must fire, which catches a strict comparison. Thresholds are written beyond the range on both sides, and a missing clamp would wrap them into wrong limits. Discovery is driven with a correct chain, a zero first word, a wrong reversed address and a chain that never terminates. An unreversed address check or an off-by-one limit would then report a bogus device count.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_HI    = 31;
  localparam int ADDR_LO    = 27;
  localparam int ADDR_W     = ADDR_HI - ADDR_LO + 1;
  localparam int IDX_HI     = 26;
  localparam int IDX_LO     = 23;
  localparam int IDX_W      = IDX_HI - IDX_LO + 1;
  localparam int VAL_HI     = 22;
  localparam int VAL_LO     = 11;
  localparam int VAL_W      = VAL_HI - VAL_LO + 1;
  localparam int MSG_LO     = 10;
  localparam int CRC_HI     = 9;
  localparam int CRC_LO     = 2;
  localparam int CRC_W      = CRC_HI - CRC_LO + 1;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h2F;
  localparam int CELL_CH    = 6;
  localparam int CH_PER_DEV = 12;
  localparam int SLOT_W     = $clog2(CH_PER_DEV);
  localparam int NUM_THR    = 4;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_SCAN = 2'd1,
    MODE_DISC = 2'd2
  } mode_t;
endpackage

// File: rtl/cm_crc_check.sv
module cm_crc_check
  import cm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              crc_ok
);
  function automatic logic [CRC_W-1:0] shift8(input logic [CRC_W-1:0] x);
    logic [CRC_W-1:0] r;
    r = x;
    for (int i = 0; i < CRC_W; i++) begin
      r = r[CRC_W-1] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

  logic [CRC_W-1:0] stage_a, stage_b, expect_crc;

  always_comb begin
    stage_a    = shift8({2'b00, word[31:26]});
    stage_b    = shift8(stage_a ^ word[25:18]);
    expect_crc = stage_b ^ word[17:MSG_LO];
    crc_ok     = (expect_crc == word[CRC_HI:CRC_LO]);
  end
endmodule

// File: rtl/cm_thresh_regs.sv
module cm_thresh_regs
  import cm_pkg::*;
#(
  parameter int THR_W = 8,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [WIN_W-1:0] wdata,
  output logic [THR_W-1:0] cell_hi,
  output logic [THR_W-1:0] cell_lo,
  output logic [THR_W-1:0] aux_hi,
  output logic [THR_W-1:0] aux_lo
);
  logic             is_neg, is_big;
  logic [THR_W-1:0] clamped;
  logic [THR_W-1:0] thr_q [NUM_THR];

  always_comb begin
    is_neg  = wdata[WIN_W-1];
    is_big  = !is_neg && (wdata[WIN_W-2:THR_W] != '0);
    clamped = is_neg ? '0 : (is_big ? '1 : wdata[THR_W-1:0]);
  end

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    localparam logic [THR_W-1:0] RST_VAL = (g % 2 == 0) ? {THR_W{1'b1}} : '0;
    always_ff @(posedge clk) begin
      if (rst) begin
        thr_q[g] <= RST_VAL;
      end else if (we && sel == 2'(g)) begin
        thr_q[g] <= clamped;
      end
    end
  end

  assign cell_hi = thr_q[0];
  assign cell_lo = thr_q[1];
  assign aux_hi  = thr_q[2];
  assign aux_lo  = thr_q[3];
endmodule

// File: rtl/cm_event_cmp.sv
module cm_event_cmp
  import cm_pkg::*;
#(
  parameter int THR_W = 8
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [VAL_W-1:0] val,
  input  logic [THR_W-1:0] cell_hi,
  input  logic [THR_W-1:0] cell_lo,
  input  logic [THR_W-1:0] aux_hi,
  input  logic [THR_W-1:0] aux_lo,
  output logic             is_cell,
  output logic             hit,
  output logic             rise
);
  logic [THR_W-1:0] hi_sel, lo_sel;
  logic             above, below;

  always_comb begin
    is_cell = (idx < IDX_W'(CELL_CH));
    hi_sel  = is_cell ? cell_hi : aux_hi;
    lo_sel  = is_cell ? cell_lo : aux_lo;
    above   = (val >= VAL_W'(hi_sel));
    below   = (val <= VAL_W'(lo_sel));
    hit     = above || below;
    rise    = above;
  end
endmodule

// File: rtl/cm_chain_readback.sv
module cm_chain_readback
  import cm_pkg::*;
#(
  parameter int MAX_DEV = 8,
  parameter int THR_W   = 8,
  parameter int WIN_W   = 16,
  localparam int DEV_W  = $clog2(MAX_DEV),
  localparam int CNT_W  = $clog2(MAX_DEV + 1),
  localparam int SUM_W  = VAL_W + $clog2(MAX_DEV * CELL_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_scan,
  input  logic              start_disc,
  input  logic [CNT_W-1:0]  dev_count,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic              thr_we,
  input  logic [1:0]        thr_sel,
  input  logic [WIN_W-1:0]  thr_wdata,
  output logic              busy,
  output logic              res_done,
  output logic              res_err,
  output logic [SUM_W-1:0]  res_sum,
  output logic [DEV_W-1:0]  res_last,
  output logic              ev_valid,
  output logic [IDX_W-1:0]  ev_chan,
  output logic [DEV_W-1:0]  ev_dev,
  output logic              ev_rise
);
  mode_t              mode_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [DEV_W-1:0]   dev_q;
  logic [DEV_W-1:0]   last_dev_q;
  logic [CNT_W-1:0]   disc_q;
  logic               crc_ok;
  logic [THR_W-1:0]   cell_hi, cell_lo, aux_hi, aux_lo;
  logic               is_cell, hit, rise;
  logic [ADDR_W-1:0]  addr_rev;
  logic [IDX_W-1:0]   w_idx;
  logic [VAL_W-1:0]   w_val;
  logic               count_bad, scan_last, addr_bad;

  assign w_idx = word_data[IDX_HI:IDX_LO];
  assign w_val = word_data[VAL_HI:VAL_LO];

  for (genvar g = 0; g < ADDR_W; g++) begin : g_rev
    assign addr_rev[g] = word_data[ADDR_HI - g];
  end

  cm_crc_check u_crc (
    .word   (word_data),
    .crc_ok (crc_ok)
  );

  cm_thresh_regs #(.THR_W(THR_W), .WIN_W(WIN_W)) u_thr (
    .clk     (clk),
    .rst     (rst),
    .we      (thr_we),
    .sel     (thr_sel),
    .wdata   (thr_wdata),
    .cell_hi (cell_hi),
    .cell_lo (cell_lo),
    .aux_hi  (aux_hi),
    .aux_lo  (aux_lo)
  );

  cm_event_cmp #(.THR_W(THR_W)) u_cmp (
    .idx     (w_idx),
    .val     (w_val),
    .cell_hi (cell_hi),
    .cell_lo (cell_lo),
    .aux_hi  (aux_hi),
    .aux_lo  (aux_lo),
    .is_cell (is_cell),
    .hit     (hit),
    .rise    (rise)
  );

  always_comb begin
    count_bad = (dev_count == '0) || (dev_count > CNT_W'(MAX_DEV));
    scan_last = (dev_q == last_dev_q) && (slot_q == SLOT_W'(CH_PER_DEV - 1));
    addr_bad  = (addr_rev != ADDR_W'(disc_q));
  end

  assign busy = (mode_q != MODE_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_IDLE;
      slot_q     <= '0;
      dev_q      <= '0;
      last_dev_q <= '0;
      disc_q     <= '0;
      res_done   <= 1'b0;
      res_err    <= 1'b0;
      res_sum    <= '0;
      res_last   <= '0;
      ev_valid   <= 1'b0;
      ev_chan    <= '0;
      ev_dev     <= '0;
      ev_rise    <= 1'b0;
    end else begin
      res_done <= 1'b0;
      res_err  <= 1'b0;
      ev_valid <= 1'b0;
      unique case (mode_q)
        MODE_IDLE: begin
          if (start_scan) begin
            if (count_bad) begin
              res_done <= 1'b1;
              res_err  <= 1'b1;
            end else begin
              mode_q     <= MODE_SCAN;
              res_sum    <= '0;
              slot_q     <= '0;
              dev_q      <= '0;
              last_dev_q <= DEV_W'(dev_count - 1'b1);
            end
          end else if (start_disc) begin
            mode_q <= MODE_DISC;
            disc_q <= '0;
          end
        end
        MODE_SCAN: begin
          if (word_valid) begin
            if (!crc_ok) begin
              res_done <= 1'b1;
              res_err  <= 1'b1;
              mode_q   <= MODE_IDLE;
            end else begin
              if (is_cell) res_sum <= res_sum + SUM_W'(w_val);
              ev_valid <= hit;
              ev_chan  <= w_idx;
              ev_dev   <= dev_q;
              ev_rise  <= rise;
              if (scan_last) begin
                res_done <= 1'b1;
                mode_q   <= MODE_IDLE;
              end else if (slot_q == SLOT_W'(CH_PER_DEV - 1)) begin
                slot_q <= '0;
                dev_q  <= dev_q + 1'b1;
              end else begin
                slot_q <= slot_q + 1'b1;
              end
            end
          end
        end
        MODE_DISC: begin
          if (word_valid) begin
            if (word_data == '0) begin
              res_done <= 1'b1;
              mode_q   <= MODE_IDLE;
              if (disc_q == '0) res_err <= 1'b1;
              else              res_last <= DEV_W'(disc_q - 1'b1);
            end else if (!crc_ok || addr_bad || disc_q == CNT_W'(MAX_DEV)) begin
              res_done <= 1'b1;
              res_err  <= 1'b1;
              mode_q   <= MODE_IDLE;
            end else begin
              disc_q <= disc_q + 1'b1;
            end
          end
        end
        default: mode_q <= MODE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cm_chain_readback_sva.sv
module cm_chain_readback_sva #(
  parameter int SUM_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             start_scan,
  input logic             start_disc,
  input logic             word_valid,
  input logic             crc_ok,
  input logic             busy,
  input logic             res_done,
  input logic             res_err,
  input logic [SUM_W-1:0] res_sum,
  input logic             ev_valid
);
  AST_ERR_IMPLIES_DONE: assert property (@(posedge clk) disable iff (rst)
    res_err |-> res_done); // R1

  AST_BADCRC_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    (busy && word_valid && !crc_ok) |=> !ev_valid); // R1

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    res_done |-> !busy); // R2

  AST_IDLE_SUM_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_scan) |=> $stable(res_sum)); // R3

  AST_EVENT_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> ($past(word_valid) && $past(busy))); // R10

  AST_DISC_STARTS: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_disc && !start_scan) |=> busy); // R7
endmodule

bind cm_chain_readback cm_chain_readback_sva #(.SUM_W(SUM_W)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .start_scan (start_scan),
  .start_disc (start_disc),
  .word_valid (word_valid),
  .crc_ok     (crc_ok),
  .busy       (busy),
  .res_done   (res_done),
  .res_err    (res_err),
  .res_sum    (res_sum),
  .ev_valid   (ev_valid)
);

// File: tb/cm_chain_readback_bench.sv
`timescale 1ns/1ps
module cm_chain_readback_bench;
  localparam int MAXD = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_scan = 1'b0, start_disc = 1'b0;
  logic [3:0]  dev_count = '0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        thr_we = 1'b0;
  logic [1:0]  thr_sel = '0;
  logic [15:0] thr_wdata = '0;
  logic        busy, res_done, res_err, ev_valid, ev_rise;
  logic [17:0] res_sum;
  logic [2:0]  res_last, ev_dev;
  logic [3:0]  ev_chan;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  cm_chain_readback u_cm_chain_readback (
    .clk(clk), .rst(rst), .start_scan(start_scan), .start_disc(start_disc),
    .dev_count(dev_count), .word_valid(word_valid), .word_data(word_data),
    .thr_we(thr_we), .thr_sel(thr_sel), .thr_wdata(thr_wdata),
    .busy(busy), .res_done(res_done), .res_err(res_err), .res_sum(res_sum),
    .res_last(res_last), .ev_valid(ev_valid), .ev_chan(ev_chan),
    .ev_dev(ev_dev), .ev_rise(ev_rise)
  );

  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  int m_mode = 0;  // 0 idle, 1 scan, 2 discovery
  int m_slot, m_dev, m_n, m_cnt;
  int m_sum = 0, m_last = 0;
  int m_done = 0, m_err = 0, m_ev = 0, m_evch = 0, m_evdev = 0, m_evrise = 0;
  int m_thr[4] = '{255, 0, 255, 0};

  function automatic int crc_rem(input logic [31:0] w);
    int r = 0;
    for (int i = 31; i >= 10; i--) begin
      r = (r << 1) | int'(w[i]);
      if (r & 'h100) r = r ^ 'h12F;
    end
    return r;
  endfunction

  function automatic int rev5(input int a);
    int r = 0;
    for (int i = 0; i < 5; i++) if (a & (1 << i)) r |= 1 << (4 - i);
    return r;
  endfunction

  function automatic logic [31:0] mk_word(input int addr, input int idx, input int val);
    logic [31:0] w;
    w = '0;
    w[31:27] = 5'(addr);
    w[26:23] = 4'(idx);
    w[22:11] = 12'(val);
    w[9:2]   = 8'(crc_rem(w));
    return w;
  endfunction

  always @(posedge clk) begin
    m_done = 0; m_err = 0; m_ev = 0;
    if (rst) begin
      m_mode = 0; m_sum = 0; m_last = 0; m_evch = 0; m_evdev = 0; m_evrise = 0;
      m_thr = '{255, 0, 255, 0};
    end else begin
      case (m_mode)
        0: begin
          if (start_scan) begin
            if (dev_count < 1 || dev_count > MAXD) begin
              m_done = 1; m_err = 1;
            end else begin
              m_mode = 1; m_sum = 0; m_slot = 0; m_dev = 0; m_n = dev_count;
            end
          end else if (start_disc) begin
            m_mode = 2; m_cnt = 0;
          end
        end
        1: if (word_valid) begin
          if (crc_rem(word_data) != int'(word_data[9:2])) begin
            m_done = 1; m_err = 1; m_mode = 0;
          end else begin
            int idx, val, hi, lo;
            idx = word_data[26:23];
            val = word_data[22:11];
            if (idx <= 5) begin m_sum += val; hi = m_thr[0]; lo = m_thr[1]; end
            else begin hi = m_thr[2]; lo = m_thr[3]; end
            m_evch = idx; m_evdev = m_dev;
            if (val >= hi) begin m_ev = 1; m_evrise = 1; end
            else if (val <= lo) begin m_ev = 1; m_evrise = 0; end
            else m_evrise = 0;
            m_slot++;
            if (m_slot == 12) begin m_slot = 0; m_dev++; end
            if (m_dev == m_n) begin m_done = 1; m_mode = 0; end
          end
        end
        default: if (word_valid) begin
          if (word_data == 0) begin
            m_done = 1; m_mode = 0;
            if (m_cnt == 0) m_err = 1; else m_last = m_cnt - 1;
          end else if (crc_rem(word_data) != int'(word_data[9:2]) ||
                       rev5(int'(word_data[31:27])) != m_cnt || m_cnt == MAXD) begin
            m_done = 1; m_err = 1; m_mode = 0;
          end else m_cnt++;
        end
      endcase
      if (thr_we) begin
        int v;
        v = int'($signed(thr_wdata));
        m_thr[thr_sel] = (v < 0) ? 0 : ((v > 255) ? 255 : v);
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      cmp("R10 busy", int'(busy), int'(m_mode != 0));
      cmp("R2 res_done", int'(res_done), m_done);
      cmp("R1 res_err", int'(res_err), m_err);
      cmp("R3 res_sum", int'(res_sum), m_sum);
      cmp("R7 res_last", int'(res_last), m_last);
      cmp("R4 ev_valid", int'(ev_valid), m_ev);
      if (m_ev != 0) begin
        cmp("R4 ev_chan", int'(ev_chan), m_evch);
        cmp("R4 ev_dev", int'(ev_dev), m_evdev);
        cmp("R5 ev_rise", int'(ev_rise), m_evrise);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send(input logic [31:0] w);
    word_valid = 1'b1; word_data = w;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic pulse_scan(input int n);
    start_scan = 1'b1; dev_count = 4'(n);
    @(negedge clk);
    start_scan = 1'b0;
  endtask

  task automatic pulse_disc();
    start_disc = 1'b1;
    @(negedge clk);
    start_disc = 1'b0;
  endtask

  task automatic wr_thr(input int sel, input int v);
    thr_we = 1'b1; thr_sel = 2'(sel); thr_wdata = 16'(v);
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  task automatic run_scan(input int n, input int seed, output int cell_sum);
    cell_sum = 0;
    pulse_scan(n);
    for (int d = 0; d < n; d++) begin
      for (int c = 0; c < 12; c++) begin
        int v;
        v = (seed + d * 41 + c * 23) % 320;
        if (c <= 5) cell_sum += v;
        send(mk_word(rev5(d), c, v));
      end
    end
  endtask

  initial begin
    int s;
    repeat (3) @(negedge clk);
    cmp("R12 busy after reset", int'(busy), 0);
    cmp("R12 sum after reset", int'(res_sum), 0);
    rst = 1'b0;
    @(negedge clk);

    // R10: words while idle do nothing
    send(mk_word(0, 0, 4000));
    send(mk_word(0, 7, 0));
    @(negedge clk);
    cmp("R10 idle word no event", int'(ev_valid), 0);

    // Default thresholds (R6): cell value 0 falls, 300 rises
    pulse_scan(1);
    for (int c = 0; c < 12; c++) send(mk_word(0, c, (c == 2) ? 0 : ((c == 8) ? 300 : 100)));
    cmp("R2 idle after one device", int'(busy), 0);
    cmp("R3 sum one device", int'(res_sum), 500);

    // R6 clamping then real thresholds; exact-equal boundaries (R4, R5)
    wr_thr(0, 1000);
    wr_thr(1, -5);
    pulse_scan(1);
    for (int c = 0; c < 12; c++) send(mk_word(0, c, (c < 6) ? 255 : 0));
    wr_thr(0, 200); wr_thr(1, 50); wr_thr(2, 150); wr_thr(3, 20);
    pulse_scan(1);
    send(mk_word(0, 0, 200)); send(mk_word(0, 1, 50)); send(mk_word(0, 2, 199));
    send(mk_word(0, 3, 51)); send(mk_word(0, 4, 150)); send(mk_word(0, 5, 20));
    send(mk_word(0, 6, 200)); send(mk_word(0, 7, 50)); send(mk_word(0, 8, 150));
    send(mk_word(0, 9, 20)); send(mk_word(0, 10, 21)); send(mk_word(0, 11, 149));
    cmp("R3 cell-only sum", int'(res_sum), 200 + 50 + 199 + 51 + 150 + 20);

    // R2/R3 multi-device scans
    run_scan(3, 7, s);
    cmp("R3 sum three devices", int'(res_sum), s);
    run_scan(8, 123, s);
    cmp("R3 sum eight devices", int'(res_sum), s);

    // Full-scale cells, eight devices, no overflow (R3)
    pulse_scan(8);
    for (int i = 0; i < 96; i++) send(mk_word(0, i % 12, 4095));
    cmp("R3 full-scale sum", int'(res_sum), 48 * 4095);

    // R1 CRC fault mid scan
    pulse_scan(2);
    for (int i = 0; i < 5; i++) send(mk_word(0, i, 60));
    send(mk_word(0, 5, 60) ^ 32'h4);
    cmp("R1 crc fault ends scan", int'(busy), 0);
    @(negedge clk);

    // R11 bad device counts
    pulse_scan(0);
    @(negedge clk);
    pulse_scan(9);
    @(negedge clk);

    // R10 start during busy ignored; simultaneous start picks scan
    pulse_scan(1);
    start_disc = 1'b1; start_scan = 1'b1; dev_count = 4'd3;
    send(mk_word(0, 0, 30));
    start_disc = 1'b0; start_scan = 1'b0;
    for (int c = 1; c < 12; c++) send(mk_word(0, c, 30));
    cmp("R10 restart ignored", int'(busy), 0);
    start_disc = 1'b1; start_scan = 1'b1; dev_count = 4'd1;
    @(negedge clk);
    start_disc = 1'b0; start_scan = 1'b0;
    for (int c = 0; c < 12; c++) send(mk_word(0, c, 1));
    cmp("R10 scan wins", int'(res_sum), 6);

    // R7 discovery of three devices
    pulse_disc();
    for (int n = 0; n < 3; n++) send(mk_word(rev5(n), 14, n * 3));
    send(32'h0);
    cmp("R7 last device index", int'(res_last), 2);
    // R7 zero first word
    pulse_disc();
    send(32'h0);
    cmp("R7 empty chain", int'(res_last), 2);
    // R8 unreversed address on device 1
    pulse_disc();
    send(mk_word(rev5(0), 14, 0));
    send(mk_word(1, 14, 0));
    @(negedge clk);
    // R1 bad CRC in discovery
    pulse_disc();
    send(mk_word(rev5(0), 14, 0) ^ 32'h100);
    @(negedge clk);
    // R9 chain that never ends
    pulse_disc();
    for (int n = 0; n <= MAXD; n++) send(mk_word(rev5(n), 14, n));
    cmp("R9 runaway chain stops", int'(busy), 0);
    // full chain of eight terminates fine
    pulse_disc();
    for (int n = 0; n < MAXD; n++) send(mk_word(rev5(n), 14, n));
    send(32'h0);
    cmp("R7 eight devices", int'(res_last), 7);

    // R12 reset mid-operation
    pulse_scan(2);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cmp("R12 reset clears sum", int'(res_sum), 0);
    @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule